// File: doc/BRIEF.md
# Four-Requester Priority Bus Arbiter

This block decides which of four requesters owns a shared bus. Each requester raises its own request line. The arbiter answers with a set of grant lines. Exactly one grant line is high while the bus is owned, and none is high while the bus is idle. Requester 0 has the highest priority and requester 3 the lowest. The grant comes straight from a register, so it follows the requests with one clock of latency.

A policy input chooses how ownership changes. Under the holding policy, an owner keeps the bus for as long as its request stays high. Higher-priority requests cannot take it away. When the owner lets go, the bus spends one cycle idle before anyone else is granted. Under the preemptive policy, the arbiter re-evaluates every cycle and gives the bus to the highest-priority active request. Ownership can move straight from one requester to another without an idle cycle.

Top module: `bus_grant_arbiter`

## Requirements
- R1: A synchronous reset (rst high at a rising edge) leaves every grant line low after that edge.
- R2: When the bus is idle and no request is high, the bus stays idle (grant 0) after the next edge.
- R3: When the bus is idle and any request is high, the next edge grants the lowest-indexed active request. Bit i of req_i belongs to requester i, bit i of grant_o grants requester i, and index 0 wins.
- R4: With mode_i = 0 (holding), an owner whose request is still high keeps its grant at the next edge, whatever other requests are high.
- R5: With mode_i = 0, when the owner's request is low at an edge, the grant goes to 0 for at least that next cycle, even if other requests are pending.
- R6: With mode_i = 1 (preemptive), each edge grants the lowest-indexed active request, even when this takes the bus from a lower-priority owner.
- R7: With mode_i = 1, a handoff from one owner to another happens in a single edge, with no idle cycle between the two grants.
- R8: With mode_i = 1, the grant goes to 0 at the next edge only when all requests are low.
- R9: The grant is registered. A change of req_i or mode_i between edges leaves grant_o unchanged until the next rising edge.
- R10: At most one grant line is high in any cycle.
- R11: A change of mode_i takes effect at the first edge where the new value is sampled, and that edge produces a single grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| mode_i | input | 1 | Policy select: 0 holding, 1 preemptive |
| req_i | input | NUM_REQ (4) | Request lines, bit 0 highest priority |
| grant_o | output | NUM_REQ (4) | One-hot grant, all zero when the bus is idle |

## Verification
Directed sequences cover several cases. They check that a higher-priority request arriving during holding ownership is ignored (R4), and that a release in holding mode inserts an idle cycle even with other requests waiting (R5). They also check that the same request pattern under the preemptive policy moves the bus in one edge (R6, R7). Random request vectors, with random policy flips, mix idle, contended and single-requester cycles. These separate a priority-order error, a missing or extra idle cycle, and a policy that is applied one edge late (R11). Between edges, the grant is sampled right after each input change to show that it only moves on a clock edge (R9).

// File: rtl/arb_pkg.sv
package arb_pkg;

    // Ownership policy applied by the next-grant logic.
    typedef enum logic {
        POL_HOLD    = 1'b0,
        POL_PREEMPT = 1'b1
    } policy_e;

    localparam int unsigned ARB_DEFAULT_PORTS = 4;

endpackage

// File: rtl/arb_lowest_pick.sv
// Finds the lowest-indexed set bit of a request vector and returns it one-hot.
module arb_lowest_pick #(
    parameter int unsigned NUM_REQ = 4
) (
    input  logic [NUM_REQ-1:0] req_i,
    output logic [NUM_REQ-1:0] pick_o,
    output logic               any_o
);

    logic [NUM_REQ-1:0] seen_w;

    genvar gi;
    generate
        for (gi = 0; gi < NUM_REQ; gi++) begin : g_chain
            if (gi == 0) begin : g_first
                assign seen_w[gi] = req_i[gi];
                assign pick_o[gi] = req_i[gi];
            end else begin : g_rest
                assign seen_w[gi] = seen_w[gi-1] | req_i[gi];
                assign pick_o[gi] = req_i[gi] & ~seen_w[gi-1];
            end
        end
    endgenerate

    assign any_o = seen_w[NUM_REQ-1];

endmodule

// File: rtl/arb_next_owner.sv
// Chooses the next grant from the current owner, the requests and the policy.
module arb_next_owner
    import arb_pkg::*;
#(
    parameter int unsigned NUM_REQ = 4
) (
    input  policy_e            policy_i,
    input  logic               busy_i,
    input  logic [NUM_REQ-1:0] grant_i,
    input  logic [NUM_REQ-1:0] req_i,
    input  logic [NUM_REQ-1:0] pick_i,
    input  logic               any_i,
    output logic [NUM_REQ-1:0] grant_o
);

    logic still_held_w;

    assign still_held_w = |(grant_i & req_i);

    always_comb begin
        grant_o = '0;
        unique case (policy_i)
            POL_HOLD: begin
                if (!busy_i) begin
                    grant_o = any_i ? pick_i : '0;
                end else if (still_held_w) begin
                    grant_o = grant_i;
                end else begin
                    grant_o = '0;
                end
            end
            POL_PREEMPT: begin
                grant_o = any_i ? pick_i : '0;
            end
            default: grant_o = '0;
        endcase
    end

endmodule

// File: rtl/bus_grant_arbiter.sv
// Four-way (parameterised) priority bus arbiter with selectable policy.
module bus_grant_arbiter
    import arb_pkg::*;
#(
    parameter int unsigned NUM_REQ = ARB_DEFAULT_PORTS
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               mode_i,
    input  logic [NUM_REQ-1:0] req_i,
    output logic [NUM_REQ-1:0] grant_o
);

    typedef struct packed {
        logic               busy;
        logic [NUM_REQ-1:0] grant;
    } arb_state_t;

    arb_state_t state_d, state_q;

    logic [NUM_REQ-1:0] pick_w;
    logic               any_w;
    logic [NUM_REQ-1:0] next_grant_w;
    policy_e            policy_w;

    assign policy_w = policy_e'(mode_i);

    arb_lowest_pick #(.NUM_REQ(NUM_REQ)) u_pick (
        .req_i  (req_i),
        .pick_o (pick_w),
        .any_o  (any_w)
    );

    arb_next_owner #(.NUM_REQ(NUM_REQ)) u_next (
        .policy_i (policy_w),
        .busy_i   (state_q.busy),
        .grant_i  (state_q.grant),
        .req_i    (req_i),
        .pick_i   (pick_w),
        .any_i    (any_w),
        .grant_o  (next_grant_w)
    );

    always_comb begin
        state_d       = state_q;
        state_d.grant = next_grant_w;
        state_d.busy  = |next_grant_w;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign grant_o = state_q.grant;

endmodule

// File: rtl/bus_grant_arbiter_chk.sv
module bus_grant_arbiter_chk #(
    parameter int unsigned NUM_REQ = 4
) (
    input logic               clk,
    input logic               rst,
    input logic               mode_i,
    input logic [NUM_REQ-1:0] req_i,
    input logic [NUM_REQ-1:0] grant_o
);

    logic [NUM_REQ-1:0] low_req_w;
    assign low_req_w = req_i & (~req_i + 1'b1);

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        $fell(rst) |-> (grant_o == '0));

    // R10
    single_grant_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant_o));

    // R2
    idle_stays_chk: assert property (@(posedge clk) disable iff (rst)
        (grant_o == '0 && req_i == '0) |=> (grant_o == '0));

    // R3
    idle_pick_chk: assert property (@(posedge clk) disable iff (rst)
        (grant_o == '0 && req_i != '0) |=> (grant_o == $past(low_req_w)));

    // R4
    hold_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (!mode_i && (|(grant_o & req_i))) |=> $stable(grant_o));

    // R5
    hold_release_chk: assert property (@(posedge clk) disable iff (rst)
        (!mode_i && grant_o != '0 && !(|(grant_o & req_i))) |=> (grant_o == '0));

    // R6
    preempt_pick_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_i && req_i != '0) |=> (grant_o == $past(low_req_w)));

    // R8
    preempt_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_i && req_i == '0) |=> (grant_o == '0));

endmodule

bind bus_grant_arbiter bus_grant_arbiter_chk #(.NUM_REQ(NUM_REQ)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .mode_i  (mode_i),
    .req_i   (req_i),
    .grant_o (grant_o)
);

// File: tb/bus_grant_arbiter_test.sv
module bus_grant_arbiter_test;

    localparam int CLK_PERIOD = 10;
    localparam int N = 4;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         mode_i = 1'b0;
    logic [N-1:0] req_i = '0;
    logic [N-1:0] grant_o;

    int total = 0;
    int bad   = 0;
    logic [N-1:0] model = '0;

    bus_grant_arbiter #(.NUM_REQ(N)) uut (
        .clk     (clk),
        .rst     (rst),
        .mode_i  (mode_i),
        .req_i   (req_i),
        .grant_o (grant_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [N-1:0] lowest(input logic [N-1:0] r);
        for (int i = 0; i < N; i++) if (r[i]) return (N'(1) << i);
        return '0;
    endfunction

    function automatic logic [N-1:0] expect_next(input logic m, input logic [N-1:0] cur,
                                                 input logic [N-1:0] r);
        if (cur == '0) return lowest(r);
        if (m) return lowest(r);
        if ((cur & r) != '0) return cur;
        return '0;
    endfunction

    function automatic string tag_of(input logic m, input logic [N-1:0] cur,
                                     input logic [N-1:0] r);
        if (cur == '0) return (r == '0) ? "R2" : "R3";
        if (!m) return ((cur & r) != '0) ? "R4" : "R5";
        if (r == '0) return "R8";
        if (lowest(r) != cur) return "R7";
        return "R6";
    endfunction

    task automatic check(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s grant actual=%b expected=%b", tag, act, exp);
        end
    endtask

    // Called at a falling edge: drive, check stability, then check after the edge.
    task automatic step(input logic m, input logic [N-1:0] r, input string force_tag);
        logic [N-1:0] exp;
        string t;
        mode_i = m;
        req_i  = r;
        exp = expect_next(m, model, r);
        t = (force_tag.len() != 0) ? force_tag : tag_of(m, model, r);
        #1;
        check("R9", grant_o, model);
        @(negedge clk);
        check(t, grant_o, exp);
        total++;
        if ($countones(grant_o) > 1) begin
            bad++;
            $display("FAIL R10 grant actual=%b expected=at most one bit", grant_o);
        end
        model = exp;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        bad++;
        total++;
        $display("FAIL watchdog grant actual=%b expected=finish", grant_o);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h00C0FFEE));
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check("R1", grant_o, '0);
        rst = 1'b0;
        model = '0;

        // idle, then a contended grab from idle
        step(1'b0, 4'b0000, "R2");
        step(1'b0, 4'b1100, "R3");       // requester 2 wins
        step(1'b0, 4'b0101, "R4");       // requester 0 arrives, owner 2 keeps
        step(1'b0, 4'b0001, "R5");       // owner drops, idle although 0 waits
        step(1'b0, 4'b0001, "R3");
        step(1'b0, 4'b1001, "R4");
        // switch to preemptive: the new policy applies at this very edge
        step(1'b1, 4'b1010, "R11");      // owner 0 gone, 1 takes over directly
        step(1'b1, 4'b1010, "R6");
        step(1'b1, 4'b1000, "R7");       // handoff 1 -> 3 with no idle
        step(1'b1, 4'b1001, "R6");       // 0 preempts 3
        step(1'b1, 4'b0000, "R8");
        step(1'b1, 4'b0100, "R3");
        // back to holding with a higher-priority request present
        step(1'b0, 4'b0111, "R11");      // owner 2 still requesting, keeps bus
        step(1'b0, 4'b0011, "R5");

        // reset in the middle of ownership
        step(1'b0, 4'b1000, "");
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check("R1", grant_o, '0);
        rst = 1'b0;
        model = '0;

        for (int k = 0; k < 3000; k++) begin
            logic m;
            logic [N-1:0] r;
            m = ((k / 40) % 2) == 1;
            if (($urandom % 16) == 0) m = ~m;
            r = N'($urandom);
            if (($urandom % 4) == 0) r = '0;
            step(m, r, "");
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule